// File: doc/BRIEF.md
# UART Receive Status and Holding Queue

This block sits between a UART's receive deserializer and the host-facing register logic. Each received character arrives with three tags: parity error, framing error and break. The block stores the character and its tags in a 16-entry holding queue. It also keeps the eight-bit line status word that the host reads. The host drains characters through a valid/ready read port. It reads the status word by pulsing a strobe in the same cycle that it samples `lsr`.

Error reporting works in two ways. The per-character flags (parity, framing, break) describe the character at the head of the queue. They rise in the cycle after a tagged character becomes the head. A separate summary flag rises as soon as an errored character is written into the queue. A status read clears every sticky flag, including the summary flag, even when errored characters are still queued.

The `mode` input selects one of three behaviours: 2'b00 normal, 2'b01 legacy (summary flag held at 0), and 2'b10 nine-bit. In nine-bit mode the parity tag is ignored, and status bit 2 carries the ninth data bit of the head character. The value 2'b11 behaves as normal mode. The receive side has no back-pressure: a valid beat is never stalled. A beat that arrives while the queue is full, with no pop in the same cycle, is dropped.

Top module: `uart_lsr_unit`

## Requirements
- R1: `rd_valid` and status bit 0 are 1 exactly while the queue holds a character. Characters leave through `rd_data` in arrival order, one for each cycle with `rd_valid && rd_ready`. The queue holds 16 characters, and the 9-bit `rx_data` is returned unchanged.
- R2: If `rx_valid` is high while 16 characters are queued and no pop happens in that cycle, the character is discarded and status bit 1 (overrun) is 1 from the next cycle. The bit stays 1 until a status read.
- R3: Outside nine-bit mode, status bit 2 becomes 1 in the cycle after a character with its parity tag becomes the queue head. It returns to 0 after a status read.
- R4: Status bit 3 (framing) and bit 4 (break) follow the same rule as R3 for their own tags, in every mode.
- R5: In nine-bit mode (mode 2'b10), status bit 2 equals `rd_data[8]` of the head character, or 0 when the queue is empty. The parity tag has no effect on it.
- R6: Status bit 5 equals `tx_fifo_empty`. Status bit 6 equals `tx_fifo_empty && tx_shift_idle`.
- R7: Status bit 7 becomes 1 in the cycle after an accepted character carrying any error tag is written. A status read clears it, even if errored characters remain queued.
- R8: In legacy mode (mode 2'b01), status bit 7 reads 0 and characters written in that mode do not set it.
- R9: In nine-bit mode, the parity tag never sets status bit 7. The framing and break tags still set it.
- R10: If a status read falls in the same cycle as an event that sets a sticky flag, the flag is 1 in the next cycle.
- R11: Before any character is written, after reset: status bits 0–4 and 7 are 0, and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 normal, 01 legacy, 10 nine-bit, 11 as normal |
| rx_valid | input | 1 | Character beat from the deserializer (never stalled) |
| rx_data | input | 9 | Received character |
| rx_par_err | input | 1 | Parity error tag |
| rx_frm_err | input | 1 | Framing error tag |
| rx_brk | input | 1 | Break tag |
| rd_valid | output | 1 | Queue head available |
| rd_ready | input | 1 | Host takes the head character |
| rd_data | output | 9 | Head character |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| tx_shift_idle | input | 1 | Transmit shifter is idle |
| lsr_rd | input | 1 | Status read strobe; clears sticky flags at the edge |
| lsr | output | 8 | Line status word |

## Verification
A wrong queue pointer or count shows at the ports in the first cycle that is affected: `rd_valid`, `rd_data` or bit 0 disagree with the character order, or the overrun bit rises one character too early or too late. A wrong head-lookahead path moves a per-character flag off by one character, so the flag appears one pop early or late. A wrong clear or set priority in the sticky flags shows in the cycle after a status read: a flag that should be 0 stays 1, or a flag that should survive a colliding set is lost. The bench compares every status bit and the read port against a queue-based model on every clock, so any of these faults is caught within one cycle of its cause.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int CHAR_W = 9;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_LEGACY = 2'b01,
    MODE_NINE   = 2'b10
  } lsr_mode_e;
endpackage

// File: rtl/uart_lsr_fifo.sv
module uart_lsr_fifo
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output rx_entry_t after_head,
  output logic [CW-1:0] count
);
  rx_entry_t mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, rd_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_nxt     = bump(rd_ptr);
  assign head       = mem[rd_ptr];
  assign after_head = mem[rd_nxt];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop)  rd_ptr <= rd_nxt;
      if (push) wr_ptr <= bump(wr_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_fifo_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == CW'(DEPTH)) |-> pop);
endmodule

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags
  import uart_lsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      head_load,
  input  rx_entry_t head_tag,
  input  logic      nine_mode,
  input  logic      legacy_mode,
  input  logic      wr_accept,
  input  rx_entry_t wr_tag,
  input  logic      overrun_evt,
  output logic      par_q,
  output logic      frm_q,
  output logic      brk_q,
  output logic      ovr_q,
  output logic      sum_q
);
  logic set_par, set_frm, set_brk, set_sum;

  always_comb begin
    set_par = head_load && head_tag.par && !nine_mode;
    set_frm = head_load && head_tag.frm;
    set_brk = head_load && head_tag.brk;
    set_sum = wr_accept && !legacy_mode &&
              ((wr_tag.par && !nine_mode) || wr_tag.frm || wr_tag.brk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      frm_q <= 1'b0;
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      sum_q <= 1'b0;
    end else begin
      par_q <= set_par     || (par_q && !clear);
      frm_q <= set_frm     || (frm_q && !clear);
      brk_q <= set_brk     || (brk_q && !clear);
      ovr_q <= overrun_evt || (ovr_q && !clear);
      sum_q <= set_sum     || (sum_q && !clear);
    end
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && head_load && head_tag.frm) |=> frm_q);
  p_nine_par_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_mode && clear && !(wr_accept && (wr_tag.frm || wr_tag.brk))) |=> !sum_q);
endmodule

// File: rtl/uart_lsr_unit.sv
module uart_lsr_unit
  import uart_lsr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [CHAR_W-1:0] rd_data,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_idle,
  input  logic              lsr_rd,
  output logic [7:0]        lsr
);
  rx_entry_t in_entry, head, after_head, head_next;
  logic [CW-1:0] count;
  logic fifo_full, rd_pop, accept, overrun_evt, head_load;
  logic nine_mode, legacy_mode;
  logic par_q, frm_q, brk_q, ovr_q, sum_q;

  always_comb begin
    in_entry    = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_data};
    nine_mode   = (mode == MODE_NINE);
    legacy_mode = (mode == MODE_LEGACY);
    rd_valid    = (count != '0);
    fifo_full   = (count == CW'(FIFO_DEPTH));
    rd_pop      = rd_valid && rd_ready;
    accept      = rx_valid && (!fifo_full || rd_pop);
    overrun_evt = rx_valid && fifo_full && !rd_pop;
    // Which character becomes the head at this edge, if any.
    head_load   = 1'b0;
    head_next   = in_entry;
    if (rd_pop) begin
      if (count > CW'(1)) begin
        head_load = 1'b1;
        head_next = after_head;
      end else begin
        head_load = accept;
      end
    end else if (!rd_valid) begin
      head_load = accept;
    end
  end

  uart_lsr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (accept),
    .push_entry (in_entry),
    .pop        (rd_pop),
    .head       (head),
    .after_head (after_head),
    .count      (count)
  );

  uart_lsr_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (lsr_rd),
    .head_load   (head_load),
    .head_tag    (head_next),
    .nine_mode   (nine_mode),
    .legacy_mode (legacy_mode),
    .wr_accept   (accept),
    .wr_tag      (in_entry),
    .overrun_evt (overrun_evt),
    .par_q       (par_q),
    .frm_q       (frm_q),
    .brk_q       (brk_q),
    .ovr_q       (ovr_q),
    .sum_q       (sum_q)
  );

  assign rd_data = head.data;

  always_comb begin
    lsr[0] = rd_valid;
    lsr[1] = ovr_q;
    lsr[2] = nine_mode ? (rd_valid && head.data[CHAR_W-1]) : par_q;
    lsr[3] = frm_q;
    lsr[4] = brk_q;
    lsr[5] = tx_fifo_empty;
    lsr[6] = tx_fifo_empty && tx_shift_idle;
    lsr[7] = sum_q && !legacy_mode;
  end

  p_overrun_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fifo_full && !rd_pop) |=> lsr[1]);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rd_pop) |=> (lsr[4:3] == 2'b00 && !lsr[1]));
  p_temt_thre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  p_legacy_bit7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEGACY) |-> !lsr[7]);
endmodule

// File: tb/uart_lsr_unit_bench.sv
module uart_lsr_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rx_valid = 1'b0;
  logic [8:0] rx_data = '0;
  logic rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [8:0] rd_data;
  logic tx_fifo_empty = 1'b1, tx_shift_idle = 1'b1;
  logic lsr_rd = 1'b0;
  logic [7:0] lsr;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_lsr_unit u_uart_lsr_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
    .lsr_rd(lsr_rd), .lsr(lsr)
  );

  // Reference model: entry = {brk, frm, par, data[8:0]}
  logic [11:0] mq[$];
  bit m_par, m_frm, m_brk, m_ovr, m_sum;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      {m_par, m_frm, m_brk, m_ovr, m_sum} = '0;
    end else begin
      automatic int sz = mq.size();
      automatic bit pop = rd_ready && sz > 0;
      automatic bit acc = rx_valid && (sz < 16 || pop);
      automatic bit ovr = rx_valid && sz == 16 && !pop;
      automatic bit nine = (mode == 2'b10);
      automatic bit leg = (mode == 2'b01);
      automatic logic [11:0] in = {rx_brk, rx_frm_err, rx_par_err, rx_data};
      automatic logic [11:0] h = '0;
      automatic bit have = 0;
      if (pop) begin
        if (sz > 1) begin h = mq[1]; have = 1; end
        else if (acc) begin h = in; have = 1; end
      end else if (sz == 0 && acc) begin h = in; have = 1; end
      m_par = (have && h[9] && !nine) || (m_par && !lsr_rd);
      m_frm = (have && h[10]) || (m_frm && !lsr_rd);
      m_brk = (have && h[11]) || (m_brk && !lsr_rd);
      m_ovr = ovr || (m_ovr && !lsr_rd);
      m_sum = (acc && !leg && ((in[9] && !nine) || in[10] || in[11])) || (m_sum && !lsr_rd);
      if (pop) void'(mq.pop_front());
      if (acc) mq.push_back(in);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit nine = (mode == 2'b10);
      automatic bit ne = mq.size() > 0;
      automatic logic [7:0] e;
      e[0] = ne;
      e[1] = m_ovr;
      e[2] = nine ? (ne && mq[0][8]) : m_par;
      e[3] = m_frm;
      e[4] = m_brk;
      e[5] = tx_fifo_empty;
      e[6] = tx_fifo_empty && tx_shift_idle;
      e[7] = (mode == 2'b01) ? 1'b0 : m_sum;
      chk(lsr[0] == e[0] && rd_valid == ne, "R1 ready/R11", {lsr[0], rd_valid}, {e[0], ne});
      chk(lsr[1] == e[1], "R2 overrun", lsr[1], e[1]);
      chk(lsr[2] == e[2], "R3/R5 bit2", lsr[2], e[2]);
      chk(lsr[4:3] == e[4:3], "R4/R10 frame-break", lsr[4:3], e[4:3]);
      chk(lsr[6:5] == e[6:5], "R6 tx", lsr[6:5], e[6:5]);
      chk(lsr[7] == e[7], "R7/R8/R9 summary", lsr[7], e[7]);
      if (ne) chk(rd_data == mq[0][8:0], "R1 data", rd_data, mq[0][8:0]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit v, input logic [8:0] d, input bit p, input bit f, input bit b,
                      input bit rr, input bit lr);
    rx_valid = v; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_brk = b;
    rd_ready = rr; lsr_rd = lr;
    @(negedge clk); #1;
    rx_valid = 0; rd_ready = 0; lsr_rd = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) step(0, '0, 0, 0, 0, 1, 0);
    step(0, '0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(2);                                  // R11 reset state
    tx_fifo_empty = 0; idle(1);               // R6
    tx_fifo_empty = 1; tx_shift_idle = 0; idle(1);
    tx_shift_idle = 1; idle(1);
    // R1 ordering
    step(1, 9'h041, 0, 0, 0, 0, 0);
    step(1, 9'h142, 0, 0, 0, 0, 0);
    step(1, 9'h043, 0, 0, 0, 1, 0);
    drain();
    // R3 and R7: parity at empty queue, then status read
    step(1, 9'h0AA, 1, 0, 0, 0, 0);
    idle(1);
    step(0, '0, 0, 0, 0, 0, 1);
    drain();
    // R4 and R7: framing behind a clean head; summary early, bit3 on pop
    step(1, 9'h011, 0, 0, 0, 0, 0);
    step(1, 9'h012, 0, 1, 0, 0, 0);
    step(1, 9'h013, 0, 0, 1, 0, 0);
    step(0, '0, 0, 0, 0, 0, 1);               // R7 cleared while errors remain
    idle(1);
    step(0, '0, 0, 0, 0, 1, 0);
    idle(1);
    step(0, '0, 0, 0, 0, 1, 1);               // R10 read collides with break head load
    idle(1);
    drain();
    // R2 overrun
    for (int i = 0; i < 16; i++) step(1, 9'(i), 0, 0, 0, 0, 0);
    step(1, 9'h1FF, 0, 0, 0, 0, 0);
    step(1, 9'h1FE, 0, 0, 0, 1, 0);           // full but pop: accepted
    idle(1);
    step(0, '0, 0, 0, 0, 0, 1);
    step(1, 9'h1FD, 1, 0, 0, 0, 1);           // R10 overrun vs read
    drain();
    // R8 legacy
    mode = 2'b01;
    step(1, 9'h055, 0, 0, 1, 0, 0);
    idle(1);
    drain();
    // R5 and R9 nine-bit
    mode = 2'b10;
    step(1, 9'h180, 1, 0, 0, 0, 0);
    step(1, 9'h001, 1, 0, 0, 0, 0);
    idle(1);
    step(0, '0, 0, 0, 0, 1, 0);
    idle(1);
    step(1, 9'h100, 0, 1, 0, 0, 0);
    idle(1);
    drain();
    mode = 2'b11;
    step(1, 9'h077, 1, 0, 0, 0, 0);
    idle(1);
    drain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule